// File: doc/BRIEF.md
# Debug Memory Access Port Register Block

This block sits behind a debug port and turns register-level debug transactions into single 32-bit accesses on a simple memory bus. Each request carries a port flag (debug-port side or access-port side), a read/write flag, a 2-bit register address and a 32-bit data word. Each request gets a registered reply one cycle later. The reply carries one of three status codes and the read data.

On the debug-port side the block holds an identification word and a power control/status register. That register carries two power-up request bits, and each request bit has an acknowledge bit that follows it after a fixed delay. The debug-port side also holds a select register, which picks the access port and the register bank, and a read buffer. On the access-port side, bank 0 of port 0 holds a control word (access size and address-increment mode), a transfer address register and a data register.

Writing the data register posts a bus write of that word to the transfer address. Reading the data register starts a bus read, and the reply returns the result of the previous read. The new result lands in the read buffer when the bus completes. While a bus access is in flight, every new request is answered with WAIT and has no effect. An access-port request made before both power acknowledges are high is answered with FAULT.

Top module: `dbg_mem_port`

## Requirements
- R1: After reset, rsp_valid and mem_req are low. The power register, select register and read buffer read 0. The control word reads 0x00000002 (32-bit size, no increment). The transfer address reads 0.
- R2: A request sampled on a clock edge gives exactly one reply, with rsp_valid high on the next cycle. Status codes are 2'b00 OK, 2'b01 WAIT and 2'b10 FAULT. rsp_rdata is 0 for writes and for any status other than OK.
- R3: Debug-port address 2'b00 reads the ID_VALUE parameter. Address 2'b10 is the select register: bits 31:24 are the access-port number, bits 7:4 are the bank, and all other bits read 0. Address 2'b11 returns the read buffer without any bus activity.
- R4: Debug-port address 2'b01 is the power register. The system power-up request is bit 30 and its acknowledge is bit 31. The debug power-up request is bit 28 and its acknowledge is bit 29. Each acknowledge register copies its request ACK_DLY cycles later (default 3), so the acknowledge first reads high on a request sampled ACK_DLY+1 edges after the write. All other bits read 0.
- R5: An access-port request made while either acknowledge is low gets FAULT. It changes no register and starts no bus access.
- R6: With port 0 and bank 0 selected, access-port address 2'b00 is the control word (bits 2:0 size, bits 5:4 increment mode), 2'b01 is the transfer address, and 2'b10 reads 0. With any other port or bank, access-port reads return 0 and writes are ignored, both with status OK.
- R7: Writing access-port address 2'b11 raises mem_req with mem_we high, the transfer address and the written data on the cycle after the request. The address, data and write enable hold stable until the cycle in which mem_ready is high, and mem_req drops after that cycle.
- R8: Reading access-port address 2'b11 starts a bus read at the transfer address. Its reply carries the read buffer's previous contents. The buffer takes mem_rdata on the completing cycle.
- R9: A request sampled while mem_req is high, including the cycle in which mem_ready completes the access, gets WAIT and has no effect.
- R10: With increment mode 2'b01, the transfer address grows after each completed bus access by 1, 2 or 4 for size 000, 001 or 010 (4 for any other size). Every other mode leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_ap | input | 1 | 1 = access-port register, 0 = debug-port register |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Register address within the selected side |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Reply strobe |
| rsp_status | output | 2 | Reply status: OK, WAIT or FAULT |
| rsp_rdata | output | 32 | Reply read data |
| mem_req | output | 1 | Bus access in flight |
| mem_we | output | 1 | Bus access is a write |
| mem_addr | output | 32 | Bus address |
| mem_wdata | output | 32 | Bus write data |
| mem_ready | input | 1 | Bus completes the access in this cycle |
| mem_rdata | input | 32 | Bus read data, valid with mem_ready |

## Verification
The assertions check on every cycle the properties that can be seen at the ports alone. These are the one-cycle reply, the legal status codes with zeroed data on non-OK replies, WAIT for any request during a bus access, a stable bus until ready, and the rule that a bus access starts only behind an OK reply. The bench's cycle model covers the behaviours that need state over many cycles: the acknowledge delay, the one-late read data, the address increment by size, and the mask on other ports and banks. The directed scenarios and a random burst with varying bus latency expose these.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'b00,
    ST_WAIT  = 2'b01,
    ST_FAULT = 2'b10
  } rsp_st_e;

  // debug-port register addresses
  localparam logic [1:0] DPA_IDENT = 2'b00;
  localparam logic [1:0] DPA_POWER = 2'b01;
  localparam logic [1:0] DPA_SEL   = 2'b10;
  localparam logic [1:0] DPA_RBUF  = 2'b11;

  // access-port register addresses (port 0, bank 0)
  localparam logic [1:0] APA_CTL  = 2'b00;
  localparam logic [1:0] APA_ADDR = 2'b01;
  localparam logic [1:0] APA_RSV  = 2'b10;
  localparam logic [1:0] APA_DATA = 2'b11;

  // power register bit positions
  localparam int unsigned PWR_SYS_ACK = 31;
  localparam int unsigned PWR_SYS_REQ = 30;
  localparam int unsigned PWR_DBG_ACK = 29;
  localparam int unsigned PWR_DBG_REQ = 28;

  localparam logic [1:0] INC_OFF    = 2'b00;
  localparam logic [1:0] INC_SINGLE = 2'b01;
  localparam logic [2:0] SZ_BYTE    = 3'b000;
  localparam logic [2:0] SZ_HALF    = 3'b001;
  localparam logic [2:0] SZ_WORD    = 3'b010;

  typedef struct packed {
    logic [1:0] incmode;
    logic [2:0] size;
  } xfer_ctl_t;

endpackage

// File: rtl/dmp_rst_sync.sv
module dmp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sr_q[STAGES-1];

endmodule

// File: rtl/dmp_dp_regs.sv
module dmp_dp_regs
  import dmp_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ACK_DLY = 3,
  parameter int unsigned PORT_W  = 8,
  parameter int unsigned BANK_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_we,
  input  logic [1:0]        pwr_req_wr,   // [0] system, [1] debug
  input  logic              sel_we,
  input  logic [PORT_W-1:0] port_wr,
  input  logic [BANK_W-1:0] bank_wr,
  output logic [DATA_W-1:0] pwr_rd,
  output logic [DATA_W-1:0] sel_rd,
  output logic [PORT_W-1:0] port_sel,
  output logic [BANK_W-1:0] bank_sel,
  output logic              pwr_ok
);

  localparam int unsigned PORT_LSB = DATA_W - PORT_W;
  localparam int unsigned BANK_LSB = 4;

  logic [1:0]        req_q, req_d;
  logic [1:0]        ack;
  logic [PORT_W-1:0] port_q, port_d;
  logic [BANK_W-1:0] bank_q, bank_d;

  always_comb begin
    req_d  = pwr_we ? pwr_req_wr : req_q;
    port_d = sel_we ? port_wr : port_q;
    bank_d = sel_we ? bank_wr : bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      port_q <= '0;
      bank_q <= '0;
    end else begin
      req_q  <= req_d;
      port_q <= port_d;
      bank_q <= bank_d;
    end
  end

  // one delay line per power domain
  for (genvar d = 0; d < 2; d++) begin : g_pwr
    logic [ACK_DLY-1:0] dly_q, dly_d;
    if (ACK_DLY == 1) begin : g_short
      assign dly_d = req_q[d];
    end else begin : g_long
      assign dly_d = {dly_q[ACK_DLY-2:0], req_q[d]};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_q <= '0;
      else        dly_q <= dly_d;
    end
    assign ack[d] = dly_q[ACK_DLY-1];
  end

  always_comb begin
    pwr_rd = '0;
    pwr_rd[PWR_SYS_ACK] = ack[0];
    pwr_rd[PWR_SYS_REQ] = req_q[0];
    pwr_rd[PWR_DBG_ACK] = ack[1];
    pwr_rd[PWR_DBG_REQ] = req_q[1];
    sel_rd = '0;
    sel_rd[PORT_LSB +: PORT_W] = port_q;
    sel_rd[BANK_LSB +: BANK_W] = bank_q;
  end

  assign port_sel = port_q;
  assign bank_sel = bank_q;
  assign pwr_ok   = &ack;

endmodule

// File: rtl/dmp_ap_regs.sv
module dmp_ap_regs
  import dmp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  xfer_ctl_t         ctl_wr,
  input  logic              addr_we,
  input  logic [DATA_W-1:0] addr_wr,
  input  logic              step,
  output xfer_ctl_t         ctl,
  output logic [DATA_W-1:0] xaddr,
  output logic [DATA_W-1:0] ctl_rd
);

  localparam int unsigned CTL_W = $bits(xfer_ctl_t);

  xfer_ctl_t         ctl_q, ctl_d;
  logic [DATA_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] stride;

  always_comb begin
    unique case (ctl_q.size)
      SZ_BYTE: stride = DATA_W'(1);
      SZ_HALF: stride = DATA_W'(2);
      default: stride = DATA_W'(4);
    endcase
  end

  always_comb begin
    ctl_d  = ctl_we ? ctl_wr : ctl_q;
    addr_d = addr_q;
    if (addr_we)
      addr_d = addr_wr;
    else if (step && ctl_q.incmode == INC_SINGLE)
      addr_d = addr_q + stride;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '{incmode: INC_OFF, size: SZ_WORD};
      addr_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      addr_q <= addr_d;
    end
  end

  assign ctl    = ctl_q;
  assign xaddr  = addr_q;
  assign ctl_rd = {{(DATA_W-CTL_W-1){1'b0}}, ctl_q.incmode, 1'b0, ctl_q.size};

endmodule

// File: rtl/dmp_bus_engine.sv
module dmp_bus_engine #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_wr,
  input  logic              issue_rd,
  input  logic [DATA_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rbuf
);

  logic              req_q, req_d;
  logic              we_q, we_d;
  logic [DATA_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic [DATA_W-1:0] rbuf_q, rbuf_d;

  assign done = req_q & mem_ready;

  always_comb begin
    req_d  = req_q;
    we_d   = we_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    rbuf_d = rbuf_q;
    if (done) begin
      req_d = 1'b0;
      if (!we_q) rbuf_d = mem_rdata;
    end else if (issue_wr || issue_rd) begin
      req_d  = 1'b1;
      we_d   = issue_wr;
      addr_d = addr_in;
      wd_d   = issue_wr ? wdata_in : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rbuf_q <= '0;
    end else begin
      req_q  <= req_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      rbuf_q <= rbuf_d;
    end
  end

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;
  assign busy      = req_q;
  assign rbuf      = rbuf_q;

endmodule

// File: rtl/dbg_mem_port.sv
module dbg_mem_port
  import dmp_pkg::*;
#(
  parameter int unsigned       DATA_W      = 32,
  parameter int unsigned       ACK_DLY     = 3,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ID_VALUE    = 32'h3E51_A0D1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ap,
  input  logic              req_rnw,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int unsigned PORT_W = 8;
  localparam int unsigned BANK_W = 4;

  logic              rst_q_n;
  logic              pwr_we, sel_we, ctl_we, addr_we, issue_wr, issue_rd;
  logic              busy, done, pwr_ok, ap_hit;
  logic [DATA_W-1:0] pwr_rd, sel_rd, ctl_rd, xaddr, rbuf, rd_mux;
  logic [PORT_W-1:0] port_sel;
  logic [BANK_W-1:0] bank_sel;
  xfer_ctl_t         ctl, ctl_wr;
  rsp_st_e           st_d;

  logic              rv_q, rv_d;
  rsp_st_e           st_q;
  logic [DATA_W-1:0] rd_q, rd_d;

  dmp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  assign ap_hit = (port_sel == '0) && (bank_sel == '0);
  assign ctl_wr = '{incmode: req_wdata[5:4], size: req_wdata[2:0]};

  // request decode: WAIT beats FAULT beats execution
  always_comb begin
    st_d     = ST_OK;
    rd_mux   = '0;
    pwr_we   = 1'b0;
    sel_we   = 1'b0;
    ctl_we   = 1'b0;
    addr_we  = 1'b0;
    issue_wr = 1'b0;
    issue_rd = 1'b0;
    if (req_valid) begin
      if (busy) begin
        st_d = ST_WAIT;
      end else if (req_ap && !pwr_ok) begin
        st_d = ST_FAULT;
      end else if (!req_ap) begin
        unique case (req_addr)
          DPA_IDENT: rd_mux = ID_VALUE;
          DPA_POWER: begin rd_mux = pwr_rd; pwr_we = !req_rnw; end
          DPA_SEL:   begin rd_mux = sel_rd; sel_we = !req_rnw; end
          default:   rd_mux = rbuf;
        endcase
      end else if (ap_hit) begin
        unique case (req_addr)
          APA_CTL:  begin rd_mux = ctl_rd; ctl_we  = !req_rnw; end
          APA_ADDR: begin rd_mux = xaddr;  addr_we = !req_rnw; end
          APA_RSV:  rd_mux = '0;
          default: begin
            rd_mux   = rbuf;
            issue_wr = !req_rnw;
            issue_rd = req_rnw;
          end
        endcase
      end
    end
  end

  assign rv_d = req_valid;
  assign rd_d = (req_valid && req_rnw && st_d == ST_OK) ? rd_mux : '0;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rv_q <= 1'b0;
      st_q <= ST_OK;
      rd_q <= '0;
    end else begin
      rv_q <= rv_d;
      st_q <= st_d;
      rd_q <= rd_d;
    end
  end

  assign rsp_valid  = rv_q;
  assign rsp_status = st_q;
  assign rsp_rdata  = rd_q;

  dmp_dp_regs #(
    .DATA_W(DATA_W), .ACK_DLY(ACK_DLY), .PORT_W(PORT_W), .BANK_W(BANK_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_q_n),
    .pwr_we(pwr_we),
    .pwr_req_wr({req_wdata[PWR_DBG_REQ], req_wdata[PWR_SYS_REQ]}),
    .sel_we(sel_we),
    .port_wr(req_wdata[DATA_W-1 -: PORT_W]),
    .bank_wr(req_wdata[4 +: BANK_W]),
    .pwr_rd(pwr_rd), .sel_rd(sel_rd),
    .port_sel(port_sel), .bank_sel(bank_sel), .pwr_ok(pwr_ok)
  );

  dmp_ap_regs #(.DATA_W(DATA_W)) u_ap (
    .clk(clk), .rst_n(rst_q_n),
    .ctl_we(ctl_we), .ctl_wr(ctl_wr),
    .addr_we(addr_we), .addr_wr(req_wdata),
    .step(done),
    .ctl(ctl), .xaddr(xaddr), .ctl_rd(ctl_rd)
  );

  dmp_bus_engine #(.DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_q_n),
    .issue_wr(issue_wr), .issue_rd(issue_rd),
    .addr_in(xaddr), .wdata_in(req_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .rbuf(rbuf)
  );

endmodule

// File: rtl/dmp_checker.sv
module dmp_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready
);

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'b11);

  // R2
  nonok_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'b00) |-> rsp_rdata == '0);

  // R9
  busy_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mem_req) |=> rsp_status == 2'b01);

  // R7
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R7
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> !mem_req);

  // R5
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'b10) |-> !mem_req);

  // R7
  start_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (rsp_valid && rsp_status == 2'b00));

endmodule

bind dbg_mem_port dmp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n),
  .req_valid(req_valid),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/dbg_mem_port_test.sv
module dbg_mem_port_test;

  localparam int          ACK = 3;
  localparam logic [31:0] TB_ID = 32'h7C2D_9E15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ap, req_rnw;
  logic [1:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready;
  logic [31:0] mem_rdata;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    ended  = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  dbg_mem_port #(.ACK_DLY(ACK), .ID_VALUE(TB_ID)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ap(req_ap), .req_rnw(req_rnw),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // ---------------- reference model ----------------
  logic [31:0] mem [logic [31:0]];
  int          relcnt;
  bit          m_rv, m_req, m_we, m_sreq, m_dreq, m_sack, m_dack, m_busy;
  logic [1:0]  m_st, m_inc;
  logic [2:0]  m_size;
  logic [7:0]  m_port;
  logic [3:0]  m_bank;
  logic [31:0] m_rd, m_addr, m_wd, m_rbuf, m_tar, m_rv_data;
  bit          sq[$];
  bit          dq[$];

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'hC3C3_0000;
  endfunction

  function automatic logic [31:0] stride(input logic [2:0] s);
    if (s == 3'b000) return 32'd1;
    if (s == 3'b001) return 32'd2;
    return 32'd4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      relcnt = 0;
      m_rv = 0; m_st = 0; m_rd = 0; m_req = 0; m_we = 0; m_addr = 0; m_wd = 0;
      m_rbuf = 0; m_tar = 0; m_size = 3'b010; m_inc = 0; m_port = 0; m_bank = 0;
      m_sreq = 0; m_dreq = 0;
      sq.delete(); dq.delete();
    end else begin
      if (relcnt < 3) relcnt++;
      if (relcnt >= 3) begin
        m_sack = (sq.size() == ACK + 1) ? sq[0] : 1'b0;
        m_dack = (dq.size() == ACK + 1) ? dq[0] : 1'b0;
        m_busy = m_req;
        if (m_req && mem_ready) begin
          m_req = 0;
          if (m_we) mem[m_addr] = m_wd;
          else      m_rbuf = mem_rdata;
          if (m_inc == 2'b01) m_tar = m_tar + stride(m_size);
        end
        m_rv = req_valid; m_st = 0; m_rd = 0;
        if (req_valid) begin
          m_rv_data = 0;
          if (m_busy) m_st = 2'b01;
          else if (req_ap && !(m_sack && m_dack)) m_st = 2'b10;
          else if (!req_ap) begin
            case (req_addr)
              2'b00: m_rv_data = TB_ID;
              2'b01: begin
                m_rv_data = {m_sack, m_sreq, m_dack, m_dreq, 28'd0};
                if (!req_rnw) begin m_sreq = req_wdata[30]; m_dreq = req_wdata[28]; end
              end
              2'b10: begin
                m_rv_data = {m_port, 16'd0, m_bank, 4'd0};
                if (!req_rnw) begin m_port = req_wdata[31:24]; m_bank = req_wdata[7:4]; end
              end
              default: m_rv_data = m_rbuf;
            endcase
          end else if (m_port == 0 && m_bank == 0) begin
            case (req_addr)
              2'b00: begin
                m_rv_data = {26'd0, m_inc, 1'b0, m_size};
                if (!req_rnw) begin m_inc = req_wdata[5:4]; m_size = req_wdata[2:0]; end
              end
              2'b01: begin
                m_rv_data = m_tar;
                if (!req_rnw) m_tar = req_wdata;
              end
              2'b10: m_rv_data = 0;
              default: begin
                m_rv_data = m_rbuf;
                m_req = 1; m_we = !req_rnw; m_addr = m_tar;
                m_wd = req_rnw ? 32'd0 : req_wdata;
              end
            endcase
          end
          if (req_rnw && m_st == 2'b00) m_rd = m_rv_data;
        end
        sq.push_back(m_sreq); if (sq.size() > ACK + 1) void'(sq.pop_front());
        dq.push_back(m_dreq); if (dq.size() > ACK + 1) void'(dq.pop_front());
      end
    end
  end

  // bus slave: latency 0..3 cycles, chosen per access
  int lat, lat_cnt;
  initial begin mem_ready = 0; mem_rdata = 0; lat = 1; lat_cnt = 0; end
  always @(negedge clk) begin
    if (m_req) begin
      if (lat_cnt >= lat) begin mem_ready = 1; mem_rdata = mem_rd(m_addr); end
      else begin mem_ready = 0; lat_cnt++; end
    end else begin
      mem_ready = 0; lat_cnt = 0;
      lat = int'($urandom_range(0, 3));
      mem_rdata = $urandom;
    end
  end

  // per-cycle comparison against the model
  logic [103:0] got_v, exp_v;
  always @(negedge clk) begin
    if (rst_n && relcnt >= 3 && !ended) begin
      got_v = {rsp_valid, rsp_valid ? rsp_status : 2'b00, rsp_valid ? rsp_rdata : 32'd0,
               mem_req, mem_req ? {mem_we, mem_addr, mem_wdata} : 65'd0};
      exp_v = {m_rv, m_rv ? m_st : 2'b00, m_rv ? m_rd : 32'd0,
               m_req, m_req ? {m_we, m_addr, m_wd} : 65'd0};
      n_chk++;
      if (got_v !== exp_v) begin
        n_fail++;
        $display("FAIL %s cycle compare: actual %h expected %h", cur_tag, got_v, exp_v);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xact(input bit ap, input bit rnw, input logic [1:0] a,
                      input logic [31:0] d, output logic [1:0] st, output logic [31:0] rd);
    req_valid = 1; req_ap = ap; req_rnw = rnw; req_addr = a; req_wdata = d;
    @(negedge clk);
    st = rsp_status; rd = rsp_rdata;
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  logic [1:0]  st;
  logic [31:0] rd;

  initial begin
    rst_n = 0; req_valid = 0; req_ap = 0; req_rnw = 0; req_addr = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);

    cur_tag = "R1";
    chk("R1 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
    chk("R1 mem_req idle", {31'd0, mem_req}, 32'd0);
    xact(0, 1, 2'b01, 0, st, rd); chk("R1 power reg", rd, 32'd0);
    xact(0, 1, 2'b10, 0, st, rd); chk("R1 select reg", rd, 32'd0);
    xact(0, 1, 2'b11, 0, st, rd); chk("R1 read buffer", rd, 32'd0);

    cur_tag = "R5";
    xact(1, 1, 2'b01, 0, st, rd);
    chk("R5 fault before power", {30'd0, st}, 32'd2);
    chk("R2 fault data zero", rd, 32'd0);
    @(negedge clk); chk("R5 no bus on fault", {31'd0, mem_req}, 32'd0);

    cur_tag = "R4";
    xact(0, 0, 2'b01, 32'h5000_0000, st, rd); chk("R2 write data zero", rd, 32'd0);
    xact(0, 1, 2'b01, 0, st, rd); chk("R4 ack not yet", rd, 32'h5000_0000);
    repeat (ACK + 2) xact(0, 1, 2'b01, 0, st, rd);
    chk("R4 acks up", rd, 32'hF000_0000);

    cur_tag = "R1";
    xact(1, 1, 2'b00, 0, st, rd); chk("R1 control word reset", rd, 32'h2);
    xact(1, 1, 2'b01, 0, st, rd); chk("R1 transfer address reset", rd, 32'd0);

    cur_tag = "R3";
    xact(0, 1, 2'b00, 0, st, rd); chk("R3 ident", rd, TB_ID);
    xact(0, 0, 2'b10, 32'hFFFF_FFFF, st, rd);
    xact(0, 1, 2'b10, 0, st, rd); chk("R3 select fields", rd, 32'hFF00_00F0);

    cur_tag = "R6";
    xact(1, 1, 2'b00, 0, st, rd); chk("R6 other port reads zero", rd, 32'd0);
    chk("R6 other port ok", {30'd0, st}, 32'd0);
    xact(1, 0, 2'b01, 32'h1234_5678, st, rd);
    xact(0, 0, 2'b10, 32'h0000_0010, st, rd);
    xact(1, 0, 2'b01, 32'h8765_4321, st, rd);
    xact(0, 0, 2'b10, 32'h0, st, rd);
    xact(1, 1, 2'b01, 0, st, rd); chk("R6 masked writes ignored", rd, 32'd0);
    xact(1, 0, 2'b00, 32'hFFFF_FFFF, st, rd);
    xact(1, 1, 2'b00, 0, st, rd); chk("R6 control fields", rd, 32'h37);
    xact(1, 0, 2'b00, 32'h2, st, rd);
    xact(1, 1, 2'b10, 0, st, rd); chk("R6 reserved reads zero", rd, 32'd0);

    cur_tag = "R7";
    xact(1, 0, 2'b01, 32'h2000_0000, st, rd);
    xact(1, 0, 2'b11, 32'hAA55_AA55, st, rd);
    chk("R7 bus request raised", {31'd0, mem_req}, 32'd1);
    chk("R7 bus address", mem_addr, 32'h2000_0000);
    chk("R7 bus data", mem_wdata, 32'hAA55_AA55);
    cur_tag = "R9";
    xact(1, 1, 2'b01, 0, st, rd); chk("R9 wait while busy", {30'd0, st}, 32'd1);
    idle(6);

    cur_tag = "R8";
    xact(1, 1, 2'b11, 0, st, rd); chk("R8 read returns previous buffer", rd, 32'd0);
    idle(6);
    xact(0, 1, 2'b11, 0, st, rd); chk("R8 buffer holds data", rd, 32'hAA55_AA55);
    xact(1, 1, 2'b01, 0, st, rd); chk("R10 no increment in mode 00", rd, 32'h2000_0000);

    cur_tag = "R10";
    xact(1, 0, 2'b00, 32'h12, st, rd);
    for (int i = 0; i < 3; i++) begin
      xact(1, 0, 2'b11, 32'h1111_0000 + i, st, rd); idle(6);
    end
    xact(1, 1, 2'b01, 0, st, rd); chk("R10 word stride", rd, 32'h2000_000C);
    xact(1, 0, 2'b00, 32'h10, st, rd);
    xact(1, 1, 2'b11, 0, st, rd); idle(6);
    xact(1, 1, 2'b01, 0, st, rd); chk("R10 byte stride", rd, 32'h2000_000D);
    xact(1, 0, 2'b00, 32'h11, st, rd);
    xact(1, 0, 2'b11, 32'h5, st, rd); idle(6);
    xact(1, 1, 2'b01, 0, st, rd); chk("R10 half stride", rd, 32'h2000_000F);
    xact(1, 0, 2'b00, 32'h22, st, rd);
    xact(1, 0, 2'b11, 32'h6, st, rd); idle(6);
    xact(1, 1, 2'b01, 0, st, rd); chk("R10 mode 10 holds", rd, 32'h2000_000F);
    xact(1, 0, 2'b01, 32'h2000_0004, st, rd);
    xact(1, 1, 2'b11, 0, st, rd); idle(6);
    xact(0, 1, 2'b11, 0, st, rd); chk("R8 buffer after read", rd, 32'h1111_0001);

    cur_tag = "R9";
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  a;
      logic [31:0] d;
      bit          ap;
      a  = 2'($urandom_range(0, 3));
      ap = ($urandom_range(0, 3) != 0);
      d  = $urandom;
      if (!ap && a == 2'b10) d = ($urandom_range(0, 5) == 0) ? d : 32'd0;
      if (!ap && a == 2'b01) d = ($urandom_range(0, 7) == 0) ? 32'd0 : 32'h5000_0000;
      if (ap && a == 2'b00)  d = {26'd0, 2'($urandom_range(0, 1)), 1'b0, 3'($urandom_range(0, 2))};
      if ($urandom_range(0, 9) < 7) xact(ap, 1'($urandom_range(0, 1)), a, d, st, rd);
      else idle(1);
    end
    idle(8);

    cur_tag = "R5";
    xact(0, 0, 2'b01, 32'h0, st, rd);
    idle(ACK + 2);
    xact(1, 1, 2'b01, 0, st, rd); chk("R5 fault after power down", {30'd0, st}, 32'd2);
    xact(1, 1, 2'b11, 0, st, rd); chk("R5 data read faults", {30'd0, st}, 32'd2);
    chk("R5 no bus after fault", {31'd0, mem_req}, 32'd0);
    idle(4);

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!ended) begin
      ended = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule